// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block is one DMA channel driven by descriptors held in memory. Software loads a chain base address and rings the doorbell. The engine then reads an eight-word descriptor over the memory read port. Once the channel enable is set, it copies the number of units the descriptor asks for. Each unit is read from the source address and written to the target address, with a byte-lane shift and byte enables for sub-word units.

Descriptor word layout, by word index: 0 command, 1 source address, 2 target address, 3 count, 4 stride difference (fetched and unused), 5 request type, 6 and 7 reserved. Count bits 23:0 hold the number of units, and bits 31:24 hold the hop to the next descriptor. That hop is measured in 16-byte steps from the chain base. When a descriptor finishes and its command bit 0 is set, the engine fetches the descriptor at that hop. A hop of zero returns to the base, so a chain can run in a loop. When a descriptor finishes with bit 0 clear, the chain ends and the channel reports completion.

Register port selects: 0 loads the chain base, 1 writes the status register, 2 is the doorbell (data bit 0). The status register layout is bit 0 enable, bit 2 halted, bit 3 chain done, bit 4 address error, bit 30 eight-word format.

Top module: `dma_link_engine`

## Requirements
- R1: After reset the status register reads 0, `irq` is low and the remaining count is 0.
- R2: A doorbell write (select 2, bit 0 set) while idle fetches descriptor words 0 to 7 from the chain base. No data is moved while status bit 0 (enable) is clear. Moving starts once it is set, whether it was set before or after the doorbell.
- R3: With command bits 23 (source increment) and 22 (target increment) set and unit size 0 (4 bytes), unit k copies the word at source+4k to target+4k with all four byte enables.
- R4: A clear increment bit keeps that address fixed for every unit of the descriptor.
- R5: Unit size is command bits 10:8, with 1 meaning 1 byte and 2 meaning 2 bytes. The unit is taken from the source byte lane and written to the target byte lane, and only that unit's byte enables are set. Addresses step by the unit size.
- R6: At the end of a descriptor with command bit 0 set, the next descriptor is fetched from base + 16 × count[31:24]. A hop of 0 goes back to the base and reloads its count, which gives a cyclic chain.
- R7: At the end of a descriptor with command bit 0 clear, status bit 3 is set and `irq` rises if command bit 1 of that descriptor is set. A descriptor with bit 0 set never sets bit 3 or `irq`.
- R8: `remainCount` shows the live unit count. It drops by one per written unit and reads 0 when the descriptor is done.
- R9: A source or target address not aligned to the unit size, or a unit size code other than 0, 1 or 2, sets status bits 4 and 2. In that case no data is written, bit 3 is not set and `irq` stays low.
- R10: Writing 0 to the status register clears every flag and stops the channel. No write follows it, even while a request is pending.
- R11: A request type of 8 moves data without a handshake. Any other value moves one unit only in a cycle where `periphReq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 base, 1 status, 2 doorbell |
| regWrData | input | 32 | Register write data |
| statusOut | output | 32 | Channel status register |
| remainCount | output | 24 | Live remaining unit count |
| irq | output | 1 | Chain-end interrupt |
| periphReq | input | 1 | Peripheral request for non-auto transfers |
| memRdEn | output | 1 | Memory read strobe, data returned next cycle |
| memRdAddr | output | 32 | Memory read byte address (word aligned) |
| memRdData | input | 32 | Memory read data |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | 32 | Memory write byte address (word aligned) |
| memWrData | output | 32 | Memory write data, lane shifted |
| memWrStrb | output | 4 | Byte enables |

## Verification
The copy path is tested with word units under each increment setting, so a fixed source (repeated data) can be told apart from a fixed target (repeated address). Byte and halfword units use unaligned but legal addresses, which shows whether the lane shift and byte enables follow the addresses rather than the size alone. A two-descriptor linked chain is run, and a looped chain is paced by `periphReq` and then aborted; these separate the hop arithmetic, wrap to the base, interrupt suppression on linked descriptors, and abort. Misaligned and illegal-size descriptors confirm that the error path writes nothing.

// File: rtl/dle_pkg.sv
package dle_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int HOP_LO     = WORD_W - 8;

  // command word bit positions
  localparam int CMD_LINK = 0;
  localparam int CMD_IE   = 1;
  localparam int CMD_SZ   = 8;
  localparam int CMD_TINC = 22;
  localparam int CMD_SINC = 23;

  // status register bit positions
  localparam int STS_EN   = 0;
  localparam int STS_HALT = 2;
  localparam int STS_DONE = 3;
  localparam int STS_AERR = 4;
  localparam int STS_FMT  = 30;

  localparam logic [1:0] SEL_BASE   = 2'd0;
  localparam logic [1:0] SEL_STATUS = 2'd1;
  localparam logic [1:0] SEL_BELL   = 2'd2;

  localparam logic [WORD_W-1:0] REQ_AUTO = 32'd8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_RQ, ST_FETCH_CAP, ST_WAIT_EN, ST_XFER_RQ, ST_XFER_WR, ST_END
  } chanState_e;

  typedef struct packed {
    logic             startChain;
    logic             nextDesc;
    logic             capWord;
    logic [IDX_W-1:0] wordIdx;
    logic             dataRead;
    logic             advance;
  } dpCtl_t;
endpackage

// File: rtl/dle_datapath.sv
module dle_datapath
  import dle_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  dpCtl_t             ctl,
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic [WORD_W-1:0]  regWrData,
  input  logic [WORD_W-1:0]  memRdData,
  output logic [ADDR_W-1:0]  memRdAddr,
  output logic [ADDR_W-1:0]  memWrAddr,
  output logic [WORD_W-1:0]  memWrData,
  output logic [3:0]         memWrStrb,
  output logic [CNT_W-1:0]   remainCount,
  output logic               cntZero,
  output logic               alignErr,
  output logic               linkBit,
  output logic               ieBit,
  output logic               autoReq
);
  logic [ADDR_W-1:0] baseReg, curDesc, srcReg, dstReg;
  logic [WORD_W-1:0] cmdReg, reqReg;
  logic [CNT_W-1:0]  cntReg;
  logic [7:0]        hopReg;
  logic [2:0]        unitBytes;
  logic              sizeOk;
  logic [1:0]        unitMask;
  logic [ADDR_W-1:0] step;
  logic [WORD_W-1:0] laneData;

  always_comb begin
    sizeOk = 1'b1;
    case (cmdReg[CMD_SZ+2:CMD_SZ])
      3'd0:    unitBytes = 3'd4;
      3'd1:    unitBytes = 3'd1;
      3'd2:    unitBytes = 3'd2;
      default: begin unitBytes = 3'd4; sizeOk = 1'b0; end
    endcase
  end

  assign unitMask = 2'(unitBytes - 3'd1);
  assign step     = ADDR_W'(unitBytes);
  assign alignErr = !sizeOk || ((srcReg[1:0] & unitMask) != 2'd0)
                            || ((dstReg[1:0] & unitMask) != 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      baseReg <= '0; curDesc <= '0; srcReg <= '0; dstReg <= '0;
      cmdReg  <= '0; reqReg  <= '0; cntReg <= '0; hopReg <= '0;
    end else begin
      if (regWrEn && regSel == SEL_BASE) baseReg <= regWrData[ADDR_W-1:0];
      if (ctl.startChain)    curDesc <= baseReg;
      else if (ctl.nextDesc) curDesc <= baseReg + ADDR_W'({hopReg, 4'b0000});
      if (ctl.capWord) begin
        case (ctl.wordIdx)
          IDX_W'(0): cmdReg <= memRdData;
          IDX_W'(1): srcReg <= memRdData[ADDR_W-1:0];
          IDX_W'(2): dstReg <= memRdData[ADDR_W-1:0];
          IDX_W'(3): begin
            cntReg <= memRdData[CNT_W-1:0];
            hopReg <= memRdData[WORD_W-1:HOP_LO];
          end
          IDX_W'(5): reqReg <= memRdData;
          default: ;
        endcase
      end
      if (ctl.advance) begin
        cntReg <= cntReg - CNT_W'(1);
        if (cmdReg[CMD_SINC]) srcReg <= srcReg + step;
        if (cmdReg[CMD_TINC]) dstReg <= dstReg + step;
      end
    end
  end

  assign memRdAddr = ctl.dataRead ? {srcReg[ADDR_W-1:2], 2'b00}
                                  : curDesc + ADDR_W'({ctl.wordIdx, 2'b00});
  assign memWrAddr = {dstReg[ADDR_W-1:2], 2'b00};
  assign laneData  = memRdData >> {srcReg[1:0], 3'b000};
  assign memWrData = laneData << {dstReg[1:0], 3'b000};

  always_comb begin
    case (unitBytes)
      3'd1:    memWrStrb = 4'b0001 << dstReg[1:0];
      3'd2:    memWrStrb = 4'b0011 << dstReg[1:0];
      default: memWrStrb = 4'b1111;
    endcase
  end

  assign remainCount = cntReg;
  assign cntZero     = (cntReg == '0);
  assign linkBit     = cmdReg[CMD_LINK];
  assign ieBit       = cmdReg[CMD_IE];
  assign autoReq     = (reqReg == REQ_AUTO);
endmodule

// File: rtl/dle_ctrl.sv
module dle_ctrl
  import dle_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [WORD_W-1:0] regWrData,
  input  logic              periphReq,
  input  logic              cntZero,
  input  logic              alignErr,
  input  logic              linkBit,
  input  logic              ieBit,
  input  logic              autoReq,
  output dpCtl_t            ctl,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [WORD_W-1:0] statusOut,
  output logic              irq
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  chanState_e state, nextState;
  logic [IDX_W-1:0] idx;
  logic en, halt, done, aerr, fmt, ieDone;
  logic statusWr, abort, bellHit, setErr, setDone;
  logic keepHalt, keepDone, keepAerr;

  assign statusWr = regWrEn && regSel == SEL_STATUS;
  assign abort    = statusWr && !regWrData[STS_EN];
  assign bellHit  = regWrEn && regSel == SEL_BELL && regWrData[0] && state == ST_IDLE;
  assign setErr   = state == ST_WAIT_EN && en && alignErr && !abort;
  assign setDone  = state == ST_END && !linkBit && !abort;
  assign keepHalt = !statusWr || regWrData[STS_HALT];
  assign keepDone = !statusWr || regWrData[STS_DONE];
  assign keepAerr = !statusWr || regWrData[STS_AERR];

  always_comb begin
    ctl         = '0;
    ctl.wordIdx = idx;
    memRdEn     = 1'b0;
    memWrEn     = 1'b0;
    nextState   = state;
    case (state)
      ST_IDLE: if (bellHit) begin ctl.startChain = 1'b1; nextState = ST_FETCH_RQ; end
      ST_FETCH_RQ: begin memRdEn = 1'b1; nextState = ST_FETCH_CAP; end
      ST_FETCH_CAP: begin
        ctl.capWord = 1'b1;
        nextState   = (idx == LAST_IDX) ? ST_WAIT_EN : ST_FETCH_RQ;
      end
      ST_WAIT_EN: if (en) nextState = alignErr ? ST_IDLE : ST_XFER_RQ;
      ST_XFER_RQ: begin
        if (cntZero) nextState = ST_END;
        else if (autoReq || periphReq) begin
          memRdEn = 1'b1; ctl.dataRead = 1'b1; nextState = ST_XFER_WR;
        end
      end
      ST_XFER_WR: begin memWrEn = 1'b1; ctl.advance = 1'b1; nextState = ST_XFER_RQ; end
      ST_END: begin
        if (linkBit) begin ctl.nextDesc = 1'b1; nextState = ST_FETCH_RQ; end
        else nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    if (abort) nextState = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; idx <= '0;
      en <= 1'b0; halt <= 1'b0; done <= 1'b0; aerr <= 1'b0; fmt <= 1'b0; ieDone <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.startChain || ctl.nextDesc) idx <= '0;
      else if (ctl.capWord)               idx <= idx + IDX_W'(1);
      if (statusWr) begin
        en  <= regWrData[STS_EN];
        fmt <= regWrData[STS_FMT];
      end
      halt   <= (halt & keepHalt & !bellHit) | setErr;
      aerr   <= (aerr & keepAerr & !bellHit) | setErr;
      done   <= (done & keepDone & !bellHit) | setDone;
      ieDone <= setDone ? ieBit : (ieDone & keepDone & !bellHit);
    end
  end

  always_comb begin
    statusOut           = '0;
    statusOut[STS_EN]   = en;
    statusOut[STS_HALT] = halt;
    statusOut[STS_DONE] = done;
    statusOut[STS_AERR] = aerr;
    statusOut[STS_FMT]  = fmt;
  end

  assign irq = done & ieDone;
endmodule

// File: rtl/dma_link_engine.sv
module dma_link_engine
  import dle_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [31:0]       regWrData,
  output logic [31:0]       statusOut,
  output logic [CNT_W-1:0]  remainCount,
  output logic              irq,
  input  logic              periphReq,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [31:0]       memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic [3:0]        memWrStrb
);
  dpCtl_t ctl;
  logic cntZero, alignErr, linkBit, ieBit, autoReq;

  dle_ctrl u_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .periphReq(periphReq), .cntZero(cntZero), .alignErr(alignErr), .linkBit(linkBit),
    .ieBit(ieBit), .autoReq(autoReq), .ctl(ctl), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .statusOut(statusOut), .irq(irq)
  );

  dle_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .memRdData(memRdData), .memRdAddr(memRdAddr),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .memWrStrb(memWrStrb),
    .remainCount(remainCount), .cntZero(cntZero), .alignErr(alignErr),
    .linkBit(linkBit), .ieBit(ieBit), .autoReq(autoReq)
  );
endmodule

// File: rtl/dle_checker.sv
module dle_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             regWrEn,
  input logic [1:0]       regSel,
  input logic [31:0]      regWrData,
  input logic             memRdEn,
  input logic             memWrEn,
  input logic [31:0]      statusOut,
  input logic [CNT_W-1:0] remainCount,
  input logic             irq
);
  a_r2_move_needs_enable: assert property (@(posedge clk) disable iff (rst)
    memWrEn |-> statusOut[0]);

  a_r3_one_port_access: assert property (@(posedge clk) disable iff (rst)
    !(memRdEn && memWrEn));

  a_r7_irq_only_when_done: assert property (@(posedge clk) disable iff (rst)
    irq |-> statusOut[3]);

  a_r8_count_per_unit: assert property (@(posedge clk) disable iff (rst)
    memWrEn |=> remainCount == $past(remainCount) - CNT_W'(1));

  a_r9_error_not_done: assert property (@(posedge clk) disable iff (rst)
    statusOut[4] |-> (statusOut[2] && !statusOut[3]));

  a_r10_zero_write_clears: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regSel == 2'd1 && regWrData == 32'd0) |=> (statusOut == 32'd0 && !irq));
endmodule

bind dma_link_engine dle_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dma_link_engine_bench.sv
module dma_link_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] statusOut;
  logic [23:0] remainCount;
  logic        irq;
  logic        periphReq = 1'b0;
  logic        memRdEn, memWrEn;
  logic [31:0] memRdAddr, memWrAddr, memWrData;
  logic [31:0] memRdData = 32'd0;
  logic [3:0]  memWrStrb;

  typedef struct {
    string       tag;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  strb;
  } wrItem_t;

  wrItem_t expQ[$];
  logic [31:0] mem [0:255];
  int nChecks = 0, nFail = 0, wrCount = 0, stopAfter = -1;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_link_engine u_dma_link_engine (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .statusOut(statusOut), .remainCount(remainCount), .irq(irq), .periphReq(periphReq),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData), .memWrStrb(memWrStrb)
  );

  // memory model: one-cycle read latency, byte-enabled writes
  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memRdAddr[9:2]];
    if (memWrEn)
      for (int b = 0; b < 4; b++)
        if (memWrStrb[b]) mem[memWrAddr[9:2]][b*8 +: 8] <= memWrData[b*8 +: 8];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes and compares
  always @(negedge clk) begin
    if (!rst && memWrEn) begin
      wrItem_t e;
      logic [31:0] m;
      wrCount++;
      if (wrCount == stopAfter) periphReq = 1'b0;
      nChecks++;
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL R10 unexpected write: got %h@%h expected none", memWrData, memWrAddr);
      end else begin
        e = expQ.pop_front();
        for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{e.strb[b]}};
        if (memWrAddr !== e.addr || memWrStrb !== e.strb || (memWrData & m) !== (e.data & m)
            || irq !== 1'b0) begin
          nFail++;
          $display("FAIL %s: got %h@%h/%b irq=%b expected %h@%h/%b irq=0", e.tag,
                   memWrData, memWrAddr, memWrStrb, irq, e.data, e.addr, e.strb);
        end
      end
    end
  end

  task automatic pushUnit(input string tag, input int sz, input logic [31:0] src, input logic [31:0] dst);
    wrItem_t e;
    logic [31:0] v;
    v = mem[src[9:2]] >> (src[1:0] * 8);
    e.tag  = tag;
    e.addr = {dst[31:2], 2'b00};
    e.data = v << (dst[1:0] * 8);
    e.strb = ((sz == 4) ? 4'hF : (sz == 2) ? 4'h3 : 4'h1) << dst[1:0];
    expQ.push_back(e);
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic putDesc(input logic [31:0] at, input logic [31:0] cmd, input logic [31:0] src,
                         input logic [31:0] dst, input logic [31:0] cnt, input logic [31:0] rtype);
    mem[at[9:2]]     = cmd;
    mem[at[9:2] + 1] = src;
    mem[at[9:2] + 2] = dst;
    mem[at[9:2] + 3] = cnt;
    mem[at[9:2] + 4] = 32'd0;
    mem[at[9:2] + 5] = rtype;
    mem[at[9:2] + 6] = 32'hDEAD_0006;
    mem[at[9:2] + 7] = 32'hDEAD_0007;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (statusOut[3] || statusOut[4]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    check({tag, " pending writes"}, expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic runOne(input logic [31:0] base);
    regWrite(2'd1, 32'd0);
    regWrite(2'd0, base);
    regWrite(2'd1, 32'h4000_0001);
    regWrite(2'd2, 32'd1);
    waitDone();
  endtask

  localparam logic [31:0] C_LINK = 32'h1, C_IE = 32'h2, C_TINC = 32'h0040_0000, C_SINC = 32'h0080_0000;

  initial begin
    int w0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h3C00_0000 + i * 32'h0105_0B11;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 status", statusOut, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 count", {8'd0, remainCount}, 32'd0);

    // R2/R3/R8: doorbell with enable clear, then enable
    putDesc(32'h000, C_SINC | C_TINC | C_IE, 32'h100, 32'h200, 32'd4, 32'd8);
    regWrite(2'd0, 32'h000);
    w0 = wrCount;
    regWrite(2'd2, 32'd1);
    repeat (40) @(negedge clk);
    check("R2 no write while disabled", wrCount - w0, 0);
    check("R8 fetched count", {8'd0, remainCount}, 32'd4);
    check("R2 status idle", statusOut, 32'd0);
    for (int k = 0; k < 4; k++) pushUnit("R3 word copy", 4, 32'h100 + 4*k, 32'h200 + 4*k);
    regWrite(2'd1, 32'h4000_0001);
    waitDone();
    check("R7 done status", statusOut, 32'h4000_0009);
    check("R7 irq with ie", {31'd0, irq}, 32'd1);
    check("R8 count at end", {8'd0, remainCount}, 32'd0);
    drained("R3");

    // R4: fixed source, interrupt disabled
    putDesc(32'h040, C_TINC, 32'h110, 32'h240, 32'd3, 32'd8);
    for (int k = 0; k < 3; k++) pushUnit("R4 fixed source", 4, 32'h110, 32'h240 + 4*k);
    runOne(32'h040);
    check("R7 done without ie", statusOut, 32'h4000_0009);
    check("R7 no irq without ie", {31'd0, irq}, 32'd0);
    drained("R4 src");

    // R4: fixed target
    putDesc(32'h080, C_SINC | C_IE, 32'h100, 32'h260, 32'd2, 32'd8);
    for (int k = 0; k < 2; k++) pushUnit("R4 fixed target", 4, 32'h100 + 4*k, 32'h260);
    runOne(32'h080);
    drained("R4 dst");

    // R5: byte units, then halfword units
    putDesc(32'h000, C_SINC | C_TINC | C_IE | (32'd1 << 8), 32'h101, 32'h283, 32'd3, 32'd8);
    for (int k = 0; k < 3; k++) pushUnit("R5 byte lanes", 1, 32'h101 + k, 32'h283 + k);
    runOne(32'h000);
    check("R5 byte done", statusOut, 32'h4000_0009);
    drained("R5 byte");
    putDesc(32'h000, C_SINC | C_TINC | C_IE | (32'd2 << 8), 32'h102, 32'h2A0, 32'd2, 32'd8);
    for (int k = 0; k < 2; k++) pushUnit("R5 half lanes", 2, 32'h102 + 2*k, 32'h2A0 + 2*k);
    runOne(32'h000);
    drained("R5 half");

    // R6/R7: linked chain, hop 3 -> base + 0x30
    putDesc(32'h000, C_LINK | C_SINC | C_TINC | C_IE, 32'h120, 32'h300, 32'h0300_0002, 32'd8);
    putDesc(32'h030, C_SINC | C_TINC | C_IE, 32'h140, 32'h310, 32'd1, 32'd8);
    pushUnit("R6 chain first", 4, 32'h120, 32'h300);
    pushUnit("R6 chain first", 4, 32'h124, 32'h304);
    pushUnit("R6 chain second", 4, 32'h140, 32'h310);
    runOne(32'h000);
    check("R7 chain end status", statusOut, 32'h4000_0009);
    check("R7 chain end irq", {31'd0, irq}, 32'd1);
    drained("R6 chain");

    // R9: misaligned source, then illegal size
    putDesc(32'h000, C_SINC | C_TINC | C_IE, 32'h102, 32'h2C0, 32'd2, 32'd8);
    runOne(32'h000);
    check("R9 misaligned status", statusOut, 32'h4000_0015);
    check("R9 misaligned irq", {31'd0, irq}, 32'd0);
    putDesc(32'h000, C_SINC | C_TINC | C_IE | (32'd3 << 8), 32'h100, 32'h2C0, 32'd2, 32'd8);
    runOne(32'h000);
    check("R9 bad size status", statusOut, 32'h4000_0015);
    drained("R9");

    // R11: request-paced transfer
    putDesc(32'h000, C_SINC | C_TINC | C_IE, 32'h150, 32'h320, 32'd3, 32'd3);
    periphReq = 1'b0;
    w0 = wrCount;
    regWrite(2'd1, 32'd0);
    regWrite(2'd0, 32'h000);
    regWrite(2'd1, 32'h4000_0001);
    regWrite(2'd2, 32'd1);
    repeat (40) @(negedge clk);
    check("R11 stalled without request", wrCount - w0, 0);
    check("R11 count held", {8'd0, remainCount}, 32'd3);
    for (int k = 0; k < 3; k++) pushUnit("R11 paced copy", 4, 32'h150 + 4*k, 32'h320 + 4*k);
    periphReq = 1'b1;
    waitDone();
    periphReq = 1'b0;
    check("R11 done", statusOut, 32'h4000_0009);
    drained("R11");

    // R6 cyclic loop (hop 0 back to base) and R10 abort
    putDesc(32'h000, C_LINK | C_SINC | C_TINC | C_IE, 32'h180, 32'h380, 32'h0200_0002, 32'd3);
    putDesc(32'h020, C_LINK | C_SINC | C_TINC | C_IE, 32'h190, 32'h390, 32'h0000_0001, 32'd3);
    for (int r = 0; r < 2; r++) begin
      pushUnit("R6 loop A", 4, 32'h180, 32'h380);
      pushUnit("R6 loop A", 4, 32'h184, 32'h384);
      pushUnit("R6 loop B", 4, 32'h190, 32'h390);
    end
    regWrite(2'd1, 32'd0);
    regWrite(2'd0, 32'h000);
    regWrite(2'd1, 32'h4000_0001);
    stopAfter = wrCount + 6;
    periphReq = 1'b1;
    regWrite(2'd2, 32'd1);
    for (int i = 0; i < 2000 && wrCount < stopAfter; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    check("R6 reloaded base count", {8'd0, remainCount}, 32'd2);
    check("R7 loop never done", statusOut, 32'h4000_0001);
    check("R7 loop no irq", {31'd0, irq}, 32'd0);
    regWrite(2'd1, 32'd0);
    check("R10 status cleared", statusOut, 32'd0);
    periphReq = 1'b1;
    repeat (40) @(negedge clk);
    check("R10 no irq", {31'd0, irq}, 32'd0);
    drained("R6 loop");

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    end
    $finish;
  end
endmodule